// File: doc/BRIEF.md
# Packet Predicate Evaluator

This block decides, for every instruction slot of an execute packet, whether that slot may commit its results. Each slot carries a 3-bit register-select code and a polarity bit. The polarity bit picks a zero test or a non-zero test. The block compares the selected condition register against that test and produces one execute-enable bit per slot. It also produces one flag per slot that marks a reserved encoding.

Eight slots are judged in parallel, all against the same copy of the five condition registers. The block takes that copy when the packet is presented. Later changes to the register inputs do not alter the verdicts for a packet that has already been captured.

A two-state controller sequences the block. In `S_IDLE` no verdicts are presented. The transition `idle_to_issue`, taken when `pkt_valid` is high, captures the packet. `S_ISSUE` presents the verdicts for one cycle. The transition `issue_to_issue`, taken when another packet arrives, captures again. The transition `issue_to_idle`, taken when no packet arrives, returns the controller to `S_IDLE`.

Top module: `pred_eval_top`

## Requirements
- R1: While reset is asserted and right after it, `out_valid`, `exec_en` and `rsvd` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `pkt_valid` high. While `out_valid` is low, `exec_en` and `rsvd` are zero.
- R3: A slot with code 000 and polarity 0 executes unconditionally, and its `rsvd` bit is 0.
- R4: With polarity 1 (zero test) and a legal register code, a slot executes only when the selected register equals 0.
- R5: With polarity 0 (non-zero test) and a legal register code, a slot executes only when the selected register is not 0.
- R6: The register codes are 001 for `cond_b0`, 010 for `cond_b1`, 011 for `cond_b2`, 100 for `cond_a1` and 101 for `cond_a2`.
- R7: The encodings code 000 with polarity 1, code 110 and code 111 are reserved. For these, `rsvd` is 1 and `exec_en` is 0.
- R8: The verdicts depend only on the register values present when `pkt_valid` was high. Register changes after that capture have no effect on the presented verdicts.
- R9: Two slots of one packet that select the same legal register with opposite polarity never both execute.
- R10: Slot i takes its code from `slot_creg[3i+2:3i]` and its polarity from `slot_z[i]`. Bit i of `exec_en` and of `rsvd` belongs to slot i, and each slot is judged independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | A packet and the register values are presented this cycle |
| slot_creg | input | 24 | Register-select codes, 3 bits per slot |
| slot_z | input | 8 | Polarity per slot: 1 = zero test, 0 = non-zero test |
| cond_b0 | input | 32 | Condition register B0 |
| cond_b1 | input | 32 | Condition register B1 |
| cond_b2 | input | 32 | Condition register B2 |
| cond_a1 | input | 32 | Condition register A1 |
| cond_a2 | input | 32 | Condition register A2 |
| out_valid | output | 1 | Verdicts are presented this cycle |
| exec_en | output | 8 | Execute enable per slot |
| rsvd | output | 8 | Reserved encoding per slot |

## Verification
Every verdict is due exactly one clock edge after the edge that samples `pkt_valid`. The bench therefore drives a packet on a falling edge, lowers `pkt_valid` on the next falling edge, and reads all outputs shortly after that edge. One cycle later it confirms that `out_valid` and the verdict buses have dropped back to zero. The snapshot property is checked inside that same verdict cycle: the bench alters every register input after the capturing edge and before it reads, so the verdicts it reads reflect only the captured values.

// File: rtl/pred_pkg.sv
package pred_pkg;
    localparam int WORD_W = 32;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_NONE = 3'b000;
    localparam logic [SEL_W-1:0] SEL_B0   = 3'b001;
    localparam logic [SEL_W-1:0] SEL_B1   = 3'b010;
    localparam logic [SEL_W-1:0] SEL_B2   = 3'b011;
    localparam logic [SEL_W-1:0] SEL_A1   = 3'b100;
    localparam logic [SEL_W-1:0] SEL_A2   = 3'b101;

    typedef struct packed {
        logic [WORD_W-1:0] b0;
        logic [WORD_W-1:0] b1;
        logic [WORD_W-1:0] b2;
        logic [WORD_W-1:0] a1;
        logic [WORD_W-1:0] a2;
    } cond_bank_t;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_ISSUE = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/pred_snapshot.sv
module pred_snapshot
    import pred_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_en,
    input  cond_bank_t             bank_in,
    input  logic [NSLOT*SEL_W-1:0] creg_in,
    input  logic [NSLOT-1:0]       z_in,
    output cond_bank_t             bank_q,
    output logic [NSLOT*SEL_W-1:0] creg_q,
    output logic [NSLOT-1:0]       z_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
            creg_q <= '0;
            z_q    <= '0;
        end else if (cap_en) begin
            bank_q <= bank_in;
            creg_q <= creg_in;
            z_q    <= z_in;
        end
    end

    // R8: the captured copy only moves on a capture cycle
    a_r8_hold_between_captures: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_en) |-> $stable(bank_q));
endmodule

// File: rtl/pred_slot_eval.sv
module pred_slot_eval
    import pred_pkg::*;
(
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             ztest,
    input  cond_bank_t       bank,
    output logic             exec,
    output logic             rsvd
);
    logic [WORD_W-1:0] picked;
    logic              legal;
    logic              uncond;
    logic              is_zero;

    always_comb begin
        picked = '0;
        legal  = 1'b1;
        uncond = 1'b0;
        unique case (sel)
            SEL_NONE: begin
                uncond = !ztest;
                legal  = !ztest;
            end
            SEL_B0:  picked = bank.b0;
            SEL_B1:  picked = bank.b1;
            SEL_B2:  picked = bank.b2;
            SEL_A1:  picked = bank.a1;
            SEL_A2:  picked = bank.a2;
            default: legal = 1'b0;
        endcase
    end

    assign is_zero = (picked == '0);

    always_comb begin
        exec = 1'b0;
        rsvd = 1'b0;
        if (en) begin
            if (!legal)      rsvd = 1'b1;
            else if (uncond) exec = 1'b1;
            else             exec = ztest ? is_zero : !is_zero;
        end
    end

    // R7: a reserved slot never commits
    always_comb begin
        a_r7_reserved_blocks: assert (!(rsvd && exec));
    end

    // R3: the all-zero code with non-zero polarity always commits when enabled
    always_comb begin
        if (en && sel == SEL_NONE && !ztest)
            a_r3_uncond: assert (exec && !rsvd);
    end
endmodule

// File: rtl/pred_eval_top.sv
module pred_eval_top
    import pred_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pkt_valid,
    input  logic [NSLOT*SEL_W-1:0] slot_creg,
    input  logic [NSLOT-1:0]       slot_z,
    input  logic [WORD_W-1:0]      cond_b0,
    input  logic [WORD_W-1:0]      cond_b1,
    input  logic [WORD_W-1:0]      cond_b2,
    input  logic [WORD_W-1:0]      cond_a1,
    input  logic [WORD_W-1:0]      cond_a2,
    output logic                   out_valid,
    output logic [NSLOT-1:0]       exec_en,
    output logic [NSLOT-1:0]       rsvd
);
    ctl_state_t state_q, state_d;
    cond_bank_t bank_in, bank_q;
    logic [NSLOT*SEL_W-1:0] creg_q;
    logic [NSLOT-1:0]       z_q;

    assign bank_in = '{b0: cond_b0, b1: cond_b1, b2: cond_b2,
                       a1: cond_a1, a2: cond_a2};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state: idle_to_issue, issue_to_issue, issue_to_idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (pkt_valid) state_d = S_ISSUE;
            S_ISSUE: state_d = pkt_valid ? S_ISSUE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs from state
    always_comb begin
        out_valid = 1'b0;
        unique case (state_q)
            S_IDLE:  out_valid = 1'b0;
            S_ISSUE: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end

    pred_snapshot #(.NSLOT(NSLOT)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (pkt_valid),
        .bank_in (bank_in),
        .creg_in (slot_creg),
        .z_in    (slot_z),
        .bank_q  (bank_q),
        .creg_q  (creg_q),
        .z_q     (z_q)
    );

    // R10: one evaluator per slot, fields taken by slot position
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        pred_slot_eval u_eval (
            .en    (out_valid),
            .sel   (creg_q[i*SEL_W +: SEL_W]),
            .ztest (z_q[i]),
            .bank  (bank_q),
            .exec  (exec_en[i]),
            .rsvd  (rsvd[i])
        );
    end

    // R2: verdicts appear exactly one cycle after a packet
    a_r2_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(pkt_valid));
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (exec_en == '0 && rsvd == '0));

    // R9: same legal register with opposite polarity never both commit
    for (genvar i = 0; i < NSLOT; i++) begin : g_mx_i
        for (genvar j = i + 1; j < NSLOT; j++) begin : g_mx_j
            a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
                (creg_q[i*SEL_W +: SEL_W] == creg_q[j*SEL_W +: SEL_W]
                 && creg_q[i*SEL_W +: SEL_W] != SEL_NONE
                 && z_q[i] != z_q[j]) |-> !(exec_en[i] && exec_en[j]));
        end
    end
endmodule

// File: tb/tb_pred_eval_top.sv
module tb_pred_eval_top;
    localparam int CLK_P = 10;
    localparam int NS    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_valid = 1'b0;
    logic [NS*3-1:0] slot_creg = '0;
    logic [NS-1:0]   slot_z = '0;
    logic [31:0] b0 = '0, b1 = '0, b2 = '0, a1 = '0, a2 = '0;
    logic out_valid;
    logic [NS-1:0] exec_en, rsvd;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    pred_eval_top #(.NSLOT(NS)) dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
        .slot_creg(slot_creg), .slot_z(slot_z),
        .cond_b0(b0), .cond_b1(b1), .cond_b2(b2),
        .cond_a1(a1), .cond_a2(a2),
        .out_valid(out_valid), .exec_en(exec_en), .rsvd(rsvd)
    );

    // expected model, from the requirements
    function automatic logic [1:0] model(input logic [2:0] c, input logic z,
                                         input logic [31:0] vb0, vb1, vb2, va1, va2);
        logic [31:0] v;
        case (c)
            3'd0: return z ? 2'b01 : 2'b10;   // {exec, rsvd}
            3'd1: v = vb0;
            3'd2: v = vb1;
            3'd3: v = vb2;
            3'd4: v = va1;
            3'd5: v = va2;
            default: return 2'b01;
        endcase
        return {(z ? (v == 0) : (v != 0)), 1'b0};
    endfunction

    function automatic string tag_of(input logic [2:0] c, input logic z);
        if (c >= 3'd6 || (c == 3'd0 && z)) return "R7";
        if (c == 3'd0) return "R3";
        return z ? "R4/R6" : "R5/R6";
    endfunction

    function automatic logic [31:0] rand_word();
        logic [31:0] r;
        r = $urandom;
        return (r[2:0] < 3) ? 32'd0 : ((r[4]) ? (32'd1 << r[9:5]) : $urandom);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive a packet; optionally scramble the registers after capture (R8)
    task automatic run_pkt(input logic [NS*3-1:0] c, input logic [NS-1:0] z,
                           input logic [31:0] vb0, vb1, vb2, va1, va2,
                           input bit scramble);
        logic [1:0] e;
        @(negedge clk);
        slot_creg = c; slot_z = z;
        b0 = vb0; b1 = vb1; b2 = vb2; a1 = va1; a2 = va2;
        pkt_valid = 1'b1;
        @(negedge clk);
        pkt_valid = 1'b0;
        if (scramble) begin
            b0 = ~vb0; b1 = ~vb1; b2 = ~vb2; a1 = ~va1; a2 = ~va2;
            slot_creg = ~c; slot_z = ~z;
        end
        #1;
        check("R2 valid", {31'd0, out_valid}, 32'd1);
        for (int i = 0; i < NS; i++) begin
            e = model(c[i*3 +: 3], z[i], vb0, vb1, vb2, va1, va2);
            check(scramble ? "R8 snapshot" : tag_of(c[i*3 +: 3], z[i]),
                  {30'd0, exec_en[i], rsvd[i]}, {30'd0, e});
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        #(CLK_P * 2 + 1);
        // R1: reset state
        check("R1", {30'd0, out_valid, |exec_en} | {24'd0, rsvd}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1", {15'd0, out_valid, exec_en, rsvd}, 32'd0);

        // R3, R7: every fixed encoding in its own slot (R10 positions)
        run_pkt({3'd7, 3'd6, 3'd0, 3'd0, 3'd7, 3'd6, 3'd0, 3'd0},
                8'b1010_0110, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 1'b0);
        // R6: each register selected, only one non-zero
        run_pkt({3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd1, 3'd2, 3'd3},
                8'h00, 32'd0, 32'd0, 32'd0, 32'h8000_0000, 32'd0, 1'b0);
        run_pkt({3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd5, 3'd4, 3'd3},
                8'hFF, 32'd1, 32'd0, 32'd1, 32'd1, 32'd1, 1'b0);

        // R9: same register opposite polarity, value zero then non-zero
        for (int k = 0; k < 2; k++) begin
            run_pkt({8{3'd2}}, 8'b0101_0101, 32'd0, k ? 32'd7 : 32'd0,
                    32'd0, 32'd0, 32'd0, 1'b0);
            check("R9 exclusive", {31'd0, &(exec_en | 8'b1010_1010) & |(exec_en & 8'b1010_1010)}, 32'd0);
        end

        // R8: inputs change after capture
        run_pkt({3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd0, 3'd1, 3'd4},
                8'b0000_1111, 32'd0, 32'd5, 32'd0, 32'd9, 32'd0, 1'b1);

        // R2: verdicts drop when no packet follows
        @(negedge clk); #1;
        check("R2 idle", {15'd0, out_valid, exec_en, rsvd}, 32'd0);

        // random packets
        for (int n = 0; n < 400; n++) begin
            logic [NS*3-1:0] c;
            logic [NS-1:0] z;
            c = {$urandom, $urandom} & {NS*3{1'b1}};
            z = $urandom;
            run_pkt(c, z, rand_word(), rand_word(), rand_word(),
                    rand_word(), rand_word(), n[3]);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule